// File: doc/BRIEF.md
# Static Backward-Taken Branch Predictor

This block sits beside the first instruction buffer of a fetch stage. It inspects the 32-bit instruction packet held there and decides, without any history, whether control will leave the sequential path. When it predicts a transfer it also produces the target address. The fetch stage uses the same-cycle flag and target to redirect its program counter and to squash the packet that follows.

The rule is fixed. Direct jumps are always predicted taken. Conditional branches are taken only when their offset is negative, which covers the loop-closing branch at the bottom of a loop. Forward branches are left to fall through. The block also keeps a registered copy of the decision, so that the flag travels with the packet when that packet moves on into the second buffer and then to decode.

The packet stream itself does not pass through this block, so the block has no valid/ready pair of its own. Back-pressure reaches it as a plain hold input, which the stage raises whenever the second buffer cannot advance. While hold is high, the registered flag keeps its value so that it stays paired with the stalled packet. A redirect flush takes priority over hold.

Top module: `bwd_branch_predictor`

## Requirements
- R1: After reset, and until the first clock edge that follows its release, the registered flag `take_aligned` is 0.
- R2: A valid packet whose opcode (instruction bits 6:0) is 1101111 is a direct jump. With no flush active, `take_now` is 1 in the same cycle and `take_target` equals the packet PC plus the sign-extended J-format immediate. That immediate is built from imm[20] = bit 31, imm[10:1] = bits 30:21, imm[11] = bit 20, imm[19:12] = bits 19:12, and imm[0] = 0.
- R3: A valid packet with opcode 1100011 and instruction bit 31 set is a backward conditional branch. With no flush active, `take_now` is 1 and `take_target` equals the packet PC plus the sign-extended B-format immediate. That immediate is built from imm[12] = bit 31, imm[10:5] = bits 30:25, imm[4:1] = bits 11:8, imm[11] = bit 7, and imm[0] = 0. The funct3 field does not affect the decision.
- R4: A valid packet with opcode 1100011 and instruction bit 31 clear is a forward branch, and `take_now` is 0.
- R5: Every other opcode gives `take_now` = 0, whatever bit 31 holds. This includes the register-indirect jump 1100111.
- R6: When `pkt_valid` is 0 (a bubble), `take_now` is 0 whatever the instruction bits are.
- R7: While `redirect_flush` is 1, `take_now` is 0. The clock edge that samples the flush clears `take_aligned`, even if hold is also high.
- R8: On a clock edge where both hold and flush are low, `take_aligned` takes the value `take_now` had in the cycle before that edge.
- R9: On a clock edge where hold is high and flush is low, `take_aligned` keeps its value.
- R10: Whenever `take_now` is 0, `take_target` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | First buffer holds a real packet (0 = bubble) |
| pkt_instr | input | 32 | Instruction word in the first buffer |
| pkt_pc | input | PC_W | Address of that instruction |
| stage_hold | input | 1 | Second buffer cannot advance; freeze the aligned flag |
| redirect_flush | input | 1 | Pipeline flush from branch resolution |
| take_now | output | 1 | Same-cycle prediction: control transfers |
| take_target | output | PC_W | Predicted target, zero when not taken |
| take_aligned | output | 1 | Registered prediction paired with the packet heading to decode |

## Verification
Direct jumps are tried with both forward and backward offsets. Taken must come from the opcode alone and not from the sign. Conditional branches are tried at the most negative offset, at small negative offsets and at forward offsets, including one case where the target wraps below address zero. Together these show whether the sign bit is decoded and whether the B-format bits are scattered correctly. A register-indirect jump and an arithmetic word, both with bit 31 set, show that the sign bit alone never predicts taken. Bubble, flush and hold sequences, including flush together with hold, separate the priorities of the registered flag.

// File: rtl/spbp_pkg.sv
package spbp_pkg;
  localparam int unsigned IW    = 32;
  localparam int unsigned OPC_W = 7;

  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_COND   = 7'b1100011;

  typedef enum logic [1:0] {
    KIND_SEQ     = 2'd0,
    KIND_JUMP    = 2'd1,
    KIND_BR_BACK = 2'd2,
    KIND_BR_FWD  = 2'd3
  } xfer_kind_e;

  function automatic logic [IW-1:0] jump_offset(input logic [IW-1:0] w);
    return {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [IW-1:0] cond_offset(input logic [IW-1:0] w);
    return {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
  endfunction
endpackage

// File: rtl/spbp_classify.sv
module spbp_classify
  import spbp_pkg::*;
(
  input  logic          valid,
  input  logic          flush,
  input  logic [IW-1:0] instr,
  output xfer_kind_e    kind,
  output logic          take
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[OPC_W-1:0];

  always_comb begin
    kind = KIND_SEQ;
    if (opc == OPC_JUMP)      kind = KIND_JUMP;
    else if (opc == OPC_COND) kind = instr[IW-1] ? KIND_BR_BACK : KIND_BR_FWD;
  end

  always_comb begin
    take = 1'b0;
    if (valid && !flush)
      take = (kind == KIND_JUMP) || (kind == KIND_BR_BACK);
  end
endmodule

// File: rtl/spbp_target.sv
module spbp_target
  import spbp_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic [IW-1:0]   instr,
  input  logic [PC_W-1:0] pc,
  input  xfer_kind_e      kind,
  input  logic            take,
  output logic [PC_W-1:0] target
);
  logic [IW-1:0]   off32;
  logic [PC_W-1:0] off;

  assign off32 = (kind == KIND_JUMP) ? jump_offset(instr) : cond_offset(instr);

  generate
    if (PC_W > IW) begin : g_widen
      assign off = {{(PC_W-IW){off32[IW-1]}}, off32};
    end else begin : g_narrow
      assign off = off32[PC_W-1:0];
    end
  endgenerate

  assign target = take ? (pc + off) : '0;
endmodule

// File: rtl/spbp_align.sv
module spbp_align (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic flush,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (flush) q <= 1'b0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/bwd_branch_predictor.sv
module bwd_branch_predictor
  import spbp_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_valid,
  input  logic [31:0]     pkt_instr,
  input  logic [PC_W-1:0] pkt_pc,
  input  logic            stage_hold,
  input  logic            redirect_flush,
  output logic            take_now,
  output logic [PC_W-1:0] take_target,
  output logic            take_aligned
);
  xfer_kind_e kind;

  spbp_classify u_cls (
    .valid (pkt_valid),
    .flush (redirect_flush),
    .instr (pkt_instr),
    .kind  (kind),
    .take  (take_now)
  );

  spbp_target #(.PC_W(PC_W)) u_tgt (
    .instr  (pkt_instr),
    .pc     (pkt_pc),
    .kind   (kind),
    .take   (take_now),
    .target (take_target)
  );

  spbp_align u_aln (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (stage_hold),
    .flush (redirect_flush),
    .d     (take_now),
    .q     (take_aligned)
  );
endmodule

// File: rtl/bwd_branch_predictor_chk.sv
module bwd_branch_predictor_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pkt_valid,
  input logic [31:0]     pkt_instr,
  input logic            stage_hold,
  input logic            redirect_flush,
  input logic            take_now,
  input logic [PC_W-1:0] take_target,
  input logic            take_aligned
);
  // R2
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !redirect_flush && pkt_instr[6:0] == 7'b1101111) |-> take_now);
  // R3
  back_branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !redirect_flush && pkt_instr[6:0] == 7'b1100011 && pkt_instr[31]) |-> take_now);
  // R4
  fwd_branch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_instr[6:0] == 7'b1100011 && !pkt_instr[31]) |-> !take_now);
  // R5
  indirect_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_instr[6:0] == 7'b1100111) |-> !take_now);
  // R6
  bubble_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !take_now);
  // R7
  flush_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_flush |-> !take_now);
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_flush |=> !take_aligned);
  // R8
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_hold && !redirect_flush) |=> (take_aligned == $past(take_now)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_hold && !redirect_flush) |=> $stable(take_aligned));
  // R10
  idle_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_now |-> (take_target == '0));
endmodule

bind bwd_branch_predictor bwd_branch_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pkt_valid      (pkt_valid),
  .pkt_instr      (pkt_instr),
  .stage_hold     (stage_hold),
  .redirect_flush (redirect_flush),
  .take_now       (take_now),
  .take_target    (take_target),
  .take_aligned   (take_aligned)
);

// File: tb/sim_bwd_branch_predictor.sv
`timescale 1ns/1ps
module sim_bwd_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [31:0] pkt_instr = '0;
  logic [31:0] pkt_pc = '0;
  logic        stage_hold = 1'b0;
  logic        redirect_flush = 1'b0;
  logic        take_now;
  logic [31:0] take_target;
  logic        take_aligned;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bwd_branch_predictor #(.PC_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_instr(pkt_instr),
    .pkt_pc(pkt_pc), .stage_hold(stage_hold), .redirect_flush(redirect_flush),
    .take_now(take_now), .take_target(take_target), .take_aligned(take_aligned)
  );

  function automatic logic [31:0] enc_jump(input int off);
    logic [20:0] i;
    i = off[20:0];
    return {i[20], i[10:1], i[11], i[19:12], 5'd1, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_cond(input int off, input logic [2:0] f3);
    logic [12:0] i;
    i = off[12:0];
    return {i[12], i[10:5], 5'd2, 5'd3, f3, i[4:1], i[11], 7'b1100011};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                     input logic hold, input logic fl);
    @(negedge clk);
    pkt_valid = v; pkt_instr = ins; pkt_pc = pc;
    stage_hold = hold; redirect_flush = fl;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 aligned in reset", {31'd0, take_aligned}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 aligned after release", {31'd0, take_aligned}, 32'd0);
  endtask

  task automatic t_jump();
    put(1, enc_jump(2048), 32'h0000_1000, 0, 0);
    chk("R2 fwd jump taken", {31'd0, take_now}, 32'd1);
    chk("R2 fwd jump target", take_target, 32'h0000_1800);
    put(1, enc_jump(-4), 32'h0000_2000, 0, 0);
    chk("R8 aligned follows jump", {31'd0, take_aligned}, 32'd1);
    chk("R2 back jump taken", {31'd0, take_now}, 32'd1);
    chk("R2 back jump target", take_target, 32'h0000_1FFC);
    put(1, enc_jump(-1048576), 32'h0010_0000, 0, 0);
    chk("R2 max back jump target", take_target, 32'h0000_0000);
  endtask

  task automatic t_back_branch();
    put(1, enc_cond(-16, 3'd0), 32'h0000_0400, 0, 0);
    chk("R3 back branch taken", {31'd0, take_now}, 32'd1);
    chk("R3 back branch target", take_target, 32'h0000_03F0);
    put(1, enc_cond(-4096, 3'd5), 32'h0000_8000, 0, 0);
    chk("R3 min offset target", take_target, 32'h0000_7000);
    put(1, enc_cond(-2, 3'd2), 32'h0000_0000, 0, 0);
    chk("R3 wrap target", take_target, 32'hFFFF_FFFE);
    put(1, enc_cond(-2050, 3'd1), 32'h0000_4000, 0, 0);
    chk("R3 bit11 target", take_target, 32'h0000_37FE);
  endtask

  task automatic t_fwd_branch();
    put(1, enc_cond(8, 3'd1), 32'h0000_0100, 0, 0);
    chk("R4 fwd branch not taken", {31'd0, take_now}, 32'd0);
    chk("R10 fwd branch target zero", take_target, 32'd0);
    put(1, enc_cond(4094, 3'd0), 32'h0000_0100, 0, 0);
    chk("R8 aligned follows fwd", {31'd0, take_aligned}, 32'd0);
    chk("R4 large fwd not taken", {31'd0, take_now}, 32'd0);
  endtask

  task automatic t_other();
    put(1, 32'hFFC0_80E7, 32'h0000_0200, 0, 0);
    chk("R5 indirect jump not taken", {31'd0, take_now}, 32'd0);
    chk("R10 indirect target zero", take_target, 32'd0);
    put(1, 32'hFFF0_0093, 32'h0000_0204, 0, 0);
    chk("R5 arith with bit31 not taken", {31'd0, take_now}, 32'd0);
  endtask

  task automatic t_bubble();
    put(0, enc_jump(64), 32'h0000_0300, 0, 0);
    chk("R6 bubble jump not taken", {31'd0, take_now}, 32'd0);
    put(0, enc_cond(-8, 3'd0), 32'h0000_0300, 0, 0);
    chk("R6 bubble branch not taken", {31'd0, take_now}, 32'd0);
    chk("R6 bubble aligned zero", {31'd0, take_aligned}, 32'd0);
  endtask

  task automatic t_flush();
    put(1, enc_jump(16), 32'h0000_0500, 0, 0);
    put(1, enc_jump(16), 32'h0000_0500, 0, 1);
    chk("R7 flush before edge aligned set", {31'd0, take_aligned}, 32'd1);
    chk("R7 flush masks take", {31'd0, take_now}, 32'd0);
    put(1, enc_jump(16), 32'h0000_0500, 0, 0);
    chk("R7 flush cleared aligned", {31'd0, take_aligned}, 32'd0);
    put(1, enc_jump(16), 32'h0000_0500, 1, 1);
    chk("R8 aligned set before flush+hold", {31'd0, take_aligned}, 32'd1);
    put(0, 32'd0, 32'd0, 1, 0);
    chk("R7 flush beats hold", {31'd0, take_aligned}, 32'd0);
  endtask

  task automatic t_hold();
    put(1, enc_cond(-32, 3'd0), 32'h0000_0600, 0, 0);
    put(1, enc_cond(32, 3'd0), 32'h0000_0604, 1, 0);
    chk("R9 aligned captured", {31'd0, take_aligned}, 32'd1);
    put(1, enc_cond(32, 3'd0), 32'h0000_0604, 1, 0);
    chk("R9 hold keeps 1", {31'd0, take_aligned}, 32'd1);
    put(1, enc_cond(32, 3'd0), 32'h0000_0604, 0, 0);
    chk("R9 hold keeps 1 again", {31'd0, take_aligned}, 32'd1);
    put(1, enc_jump(8), 32'h0000_0700, 1, 0);
    chk("R8 released to fwd", {31'd0, take_aligned}, 32'd0);
    put(0, 32'd0, 32'd0, 0, 0);
    chk("R9 hold keeps 0", {31'd0, take_aligned}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_jump();
    t_back_branch();
    t_fwd_branch();
    t_other();
    t_bubble();
    t_flush();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule